// File: doc/BRIEF.md
# Real-Time Clock Interrupt Request Flag

This block raises the interrupt request of a real-time clock. A one-cycle periodic event input asserts the request. The request is presented in two ways. The first is an output enable for an open-drain, active-low pin, where 1 means the pin is pulled low and 0 means it floats. The second is a readable flag bit in the clock's control register D, and that flag is by definition the pin state. The host clears a pending request by writing 0 to the flag position. Writing 1 there changes nothing, so a read-modify-write that keeps the bit at 1 cannot cancel a request that arrived during the access.

A mode input chooses how the request ends. In pulse mode the request releases itself after a fixed width of `PULSE_CYCLES` clock cycles. With a 32.768 kHz clock and the default of 256, this is 7.8125 ms. In level mode the request stays asserted until the host writes 0. The mode is sampled when each event arrives.

The controller has three states. `ST_IDLE` means the pin floats. `ST_PULSE` is a timed request and `ST_LEVEL` is a held request. Its transitions are:

- `EV_ARM_PULSE`: from idle to pulse, on an event in pulse mode.
- `EV_ARM_LEVEL`: from idle to level, on an event in level mode.
- `EV_RETRIGGER`: an event in any active state re-enters pulse or level according to the mode, and reloads the width timer.
- `EV_HOST_CLEAR`: from pulse or level to idle, on a write of 0 with no event in the same cycle.
- `EV_EXPIRE`: from pulse to idle, when the width timer reaches zero.

Top module: `rtc_irq_flag`

## Requirements
- R1: After reset the flag reads 0 and the pin output enable is 0 (pin floating).
- R2: The flag (`flag_o`) equals the pin output enable (`pin_oe_o`) in every cycle.
- R3: An event with `pulse_mode_i`=1 sets the flag from the next cycle. With no further event or write, the flag stays 1 for exactly `PULSE_CYCLES` cycles and then returns to 0.
- R4: An event with `pulse_mode_i`=0 sets the flag from the next cycle. The flag stays 1 until a host write clears it, however long that takes.
- R5: A write (`wr_en_i`=1) with `wr_data_i` bit 2 equal to 0 clears the flag in the next cycle, in either mode and at any point of a pulse. This includes the first cycle after the event.
- R6: A write with `wr_data_i` bit 2 equal to 1 has no effect, whatever the other data bits hold. It neither sets an idle flag nor clears an active one. When no event arrives, an idle flag stays 0.
- R7: An event in the same cycle as a clearing write wins, and the flag is 1 in the next cycle.
- R8: An event while a pulse is active restarts the width. The flag then stays 1 for exactly `PULSE_CYCLES` cycles counted from the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (32.768 kHz in the intended use) |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | One-cycle periodic interrupt event |
| pulse_mode_i | input | 1 | 1 = self-releasing pulse, 0 = level held until host clear |
| wr_en_i | input | 1 | Host write strobe for control register D |
| wr_data_i | input | REG_W | Host write data; bit FLAG_BIT (2) is the flag |
| flag_o | output | 1 | Flag bit as read from control register D |
| pin_oe_o | output | 1 | Open-drain enable: 1 pulls the interrupt pin low, 0 floats it |

## Verification
The checker watches four things in every cycle:

- the flag and the pin enable stay equal;
- every event sets the flag one cycle later, whether or not a clear arrives with it;
- a clear with no competing event releases the pin;
- an idle flag never rises without an event, even when a write of 1 arrives.

It also counts the cycles since the last pulse-mode event and checks that the flag never outlives the width.

Some behaviours only the bench scenarios can show. These are that a pulse lasts exactly the width, that a retrigger extends the pulse by a full width, and that a level request survives long idle stretches. The bench also sweeps a clear at every offset within a pulse and every data pattern that has the flag bit set.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_LEVEL = 2'd2
    } irq_state_e;

endpackage

// File: rtl/rtc_irq_wr_decode.sv
module rtc_irq_wr_decode #(
    parameter int REG_W    = 4,
    parameter int FLAG_BIT = 2
) (
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic             clr_req_o
);
    // Only a written 0 at the flag position requests a clear; 1 is inert.
    assign clr_req_o = wr_en_i & ~wr_data_i[FLAG_BIT];

    logic unused_other_bits;
    assign unused_other_bits = ^{wr_data_i[REG_W-1:FLAG_BIT+1], wr_data_i[FLAG_BIT-1:0]};
endmodule

// File: rtl/rtc_irq_width_timer.sv
module rtc_irq_width_timer #(
    parameter int WIDTH_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (WIDTH_CYC > 1) ? $clog2(WIDTH_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(WIDTH_CYC - 1);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= RELOAD;
        end else if (run_i && (remain_q != '0)) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign done_o = (remain_q == '0);
endmodule

// File: rtl/rtc_irq_fsm.sv
module rtc_irq_fsm
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic pulse_mode_i,
    input  logic clr_req_i,
    input  logic width_done_i,
    output logic timer_load_o,
    output logic timer_run_o,
    output logic req_active_o
);
    irq_state_e state_q, state_d;
    irq_state_e armed_state;

    assign armed_state = pulse_mode_i ? ST_PULSE : ST_LEVEL;

    // Next state: an event always wins over a host clear.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (evt_i) state_d = armed_state;
            end
            ST_PULSE: begin
                if (evt_i)             state_d = armed_state;
                else if (clr_req_i)    state_d = ST_IDLE;
                else if (width_done_i) state_d = ST_IDLE;
            end
            ST_LEVEL: begin
                if (evt_i)          state_d = armed_state;
                else if (clr_req_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        timer_load_o = evt_i;
        timer_run_o  = 1'b0;
        req_active_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PULSE: begin
                timer_run_o  = 1'b1;
                req_active_o = 1'b1;
            end
            ST_LEVEL: req_active_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag #(
    parameter int PULSE_CYCLES = 256,
    parameter int REG_W        = 4,
    parameter int FLAG_BIT     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             pulse_mode_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic             flag_o,
    output logic             pin_oe_o
);
    logic clr_req, width_done, timer_load, timer_run, req_active;

    rtc_irq_wr_decode #(.REG_W(REG_W), .FLAG_BIT(FLAG_BIT)) u_dec (
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .clr_req_o (clr_req)
    );

    rtc_irq_width_timer #(.WIDTH_CYC(PULSE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (timer_load),
        .run_i  (timer_run),
        .done_o (width_done)
    );

    rtc_irq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .pulse_mode_i (pulse_mode_i),
        .clr_req_i    (clr_req),
        .width_done_i (width_done),
        .timer_load_o (timer_load),
        .timer_run_o  (timer_run),
        .req_active_o (req_active)
    );

    // The readable flag is the pin drive itself.
    assign pin_oe_o = req_active;
    assign flag_o   = req_active;
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk #(
    parameter int PULSE_CYCLES = 256,
    parameter int REG_W        = 4,
    parameter int FLAG_BIT     = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_i,
    input logic             pulse_mode_i,
    input logic             wr_en_i,
    input logic [REG_W-1:0] wr_data_i,
    input logic             flag_o,
    input logic             pin_oe_o
);
    int   since_q;
    logic last_pulse_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q      <= 0;
            last_pulse_q <= 1'b0;
        end else if (evt_i) begin
            since_q      <= 1;
            last_pulse_q <= pulse_mode_i;
        end else if (flag_o && since_q < PULSE_CYCLES + 2) begin
            since_q <= since_q + 1;
        end
    end

    AST_FLAG_IS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o == pin_oe_o); // R2
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> flag_o); // R7
    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_data_i[FLAG_BIT] && !evt_i) |=> !flag_o); // R5
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !evt_i) |=> !flag_o); // R6
    AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && last_pulse_q) |-> (since_q <= PULSE_CYCLES)); // R3
endmodule

bind rtc_irq_flag rtc_irq_chk #(
    .PULSE_CYCLES (PULSE_CYCLES),
    .REG_W        (REG_W),
    .FLAG_BIT     (FLAG_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt_i),
    .pulse_mode_i (pulse_mode_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .flag_o       (flag_o),
    .pin_oe_o     (pin_oe_o)
);

// File: tb/rtc_irq_flag_tb.sv
module rtc_irq_flag_tb;
    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_i = 1'b0;
    logic       pulse_mode_i = 1'b1;
    logic       wr_en_i = 1'b0;
    logic [3:0] wr_data_i = 4'hF;
    logic       flag_o, pin_oe_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rtc_irq_flag #(.PULSE_CYCLES(W), .REG_W(4), .FLAG_BIT(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .pulse_mode_i(pulse_mode_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .flag_o(flag_o), .pin_oe_o(pin_oe_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, then sample after the edge at the next negedge.
    task automatic step(input bit e, input bit m, input bit we, input logic [3:0] wd);
        evt_i = e; pulse_mode_i = m; wr_en_i = we; wr_data_i = wd;
        @(negedge clk);
        evt_i = 1'b0; wr_en_i = 1'b0; wr_data_i = 4'hF;
        check("R2 pin equals flag", int'(pin_oe_o), int'(flag_o));
    endtask

    task automatic idle();
        step(1'b0, pulse_mode_i, 1'b0, 4'hF);
    endtask

    // Count consecutive high samples, starting with the current one.
    task automatic measure(output int n);
        n = 0;
        while (flag_o && n < 4 * W) begin
            n++;
            idle();
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        int n;
        @(negedge clk); @(negedge clk);
        check("R1 flag after reset", int'(flag_o), 0);
        check("R1 pin after reset", int'(pin_oe_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: repeated pulses, each exactly W cycles
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b1, 1'b0, 4'hF);
            measure(n);
            check("R3 pulse width", n, W);
            repeat (k + 1) idle();
        end

        // R4: level request held, R6 write 1 keeps it, R5 write 0 clears
        step(1'b1, 1'b0, 1'b0, 4'hF);
        repeat (3 * W) idle();
        check("R4 level held", int'(flag_o), 1);
        for (int d = 0; d < 16; d++) begin
            if (d[2]) begin
                step(1'b0, 1'b0, 1'b1, 4'(d));
                check("R6 write one on active", int'(flag_o), 1);
            end
        end
        step(1'b0, 1'b0, 1'b1, 4'hB);
        check("R5 level clear", int'(flag_o), 0);

        // R6: writing 1 to an idle flag never sets it
        for (int d = 0; d < 16; d++) begin
            step(1'b0, 1'b1, 1'b1, 4'(d | 4));
            check("R6 write one on idle", int'(flag_o), 0);
        end
        repeat (W + 2) idle();
        check("R6 idle stays low", int'(flag_o), 0);

        // R5: clear at every offset inside a pulse
        for (int j = 0; j < W; j++) begin
            step(1'b1, 1'b1, 1'b0, 4'hF);
            repeat (j) idle();
            check("R5 still high before clear", int'(flag_o), 1);
            step(1'b0, 1'b1, 1'b1, 4'h0);
            check("R5 pulse clear", int'(flag_o), 0);
        end

        // R7: event and clear together, both modes
        step(1'b1, 1'b1, 1'b1, 4'h0);
        check("R7 collision pulse", int'(flag_o), 1);
        measure(n);
        check("R7 collision width", n, W);
        step(1'b1, 1'b0, 1'b1, 4'h3);
        check("R7 collision level", int'(flag_o), 1);
        repeat (2 * W) idle();
        check("R7 level persists", int'(flag_o), 1);
        step(1'b1, 1'b0, 1'b1, 4'h0);
        check("R7 collision while active", int'(flag_o), 1);
        step(1'b0, 1'b0, 1'b1, 4'h0);
        check("R5 clear after collision", int'(flag_o), 0);

        // R8: retrigger at every offset restarts the full width
        for (int j = 1; j < W; j++) begin
            step(1'b1, 1'b1, 1'b0, 4'hF);
            repeat (j) idle();
            check("R8 high before retrigger", int'(flag_o), 1);
            step(1'b1, 1'b1, 1'b0, 4'hF);
            measure(n);
            check("R8 width after retrigger", n, W);
        end

        summary();
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule